// File: doc/BRIEF.md
# Embedded-Clock Word Serializer Framer

This block turns a parallel word into a serial stream whose clock can be recovered at the far end. Each parallel word is wrapped between a leading one and a trailing zero, so every twelve-bit frame carries at least one guaranteed rising transition at its boundary. The fast bit clock is the only clock of the block. The word clock enters as an ordinary signal sampled by the bit clock, and a select input picks whether its rising or its falling transition captures the parallel input.

A link partner asks for a training pattern by raising either of two sync requests. Once a request has been seen at enough consecutive frame boundaries, the data is set aside and a half-ones, half-zeros pattern goes out every word period. The pattern stops as soon as both requests are low at a boundary. An enable input masks the serial output without disturbing the framing. A power-down input stops transmission and, once it is released, forces a fixed number of silent frame boundaries to pass before anything is sent. The output is a data bit plus an output-enable flag that stands in for a tri-stateable pad.

Top module: `emb_clk_ser`

## Requirements
- R1: Every transmitted frame is FRAME_W = DATA_W+2 bits long (12 by default); its first bit is 1 (start marker) and its last bit is 0 (stop marker).
- R2: Between the markers the captured word is sent least significant bit first: frame bit k (k = 1..DATA_W) equals word bit k-1.
- R3: A bit counter starts at 0 when reset is released and advances on every bit clock. A new frame is loaded on every clock edge at which the counter holds FRAME_W-1, which is every 12th edge after reset release, so frames follow one another with no gap.
- R4: The two sync requests are ORed and sampled at each frame boundary. Only when SYNC_QUAL (default 5) consecutive boundaries sample the request high does the frame loaded at that boundary, and each frame after it, become the sync pattern. A request that lasts only four boundaries sends no sync frame.
- R5: The sync pattern is six 1 bits followed by six 0 bits, in order of transmission.
- R6: The first boundary at which both sync requests are low loads a data frame again, and the qualification count restarts from zero.
- R7: When cap_rise_i is 1, the word is captured at a clock edge where wclk_i is sampled 1 after having been sampled 0 at the edge before. When cap_rise_i is 0, it is captured at the opposite transition. Each frame carries the most recent captured word.
- R8: sdo_oe_o goes low one clock after den_i is sampled low, and sdo_o reads 0 whenever sdo_oe_o is low. Framing continues underneath, and transmission resumes one clock after den_i returns high.
- R9: While pwr_n_i is low, sdo_oe_o is low from the next clock. After pwr_n_i is first sampled high, and also after reset, the first INIT_WORDS (default 510) frame boundaries send nothing. The frame loaded at boundary INIT_WORDS+1 is the first one transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, twelve times the word rate |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| wclk_i | input | 1 | Word clock, sampled by clk |
| cap_rise_i | input | 1 | 1: capture on word clock rising transition, 0: on falling |
| din_i | input | DATA_W | Parallel word |
| sync_a_i | input | 1 | Sync request, first source |
| sync_b_i | input | 1 | Sync request, second source |
| den_i | input | 1 | Output enable request |
| pwr_n_i | input | 1 | Active-low power-down |
| sdo_o | output | 1 | Serial data, 0 while disabled |
| sdo_oe_o | output | 1 | Serial output enable (models the high-impedance control) |

## Verification
The bench goes after the exact boundary at which the first live frame appears after reset and after a power-down release. An off-by-one in the initialization count would move the rise of sdo_oe_o by twelve clocks. It holds a sync request for exactly four boundaries, where a qualification threshold one short would emit a sync frame, and it drops the request to show that data returns at the next boundary rather than one frame late. It switches the capture edge while the parallel word changes halfway through the high phase of the word clock, so a design that ignored the select would send the neighbouring word. It also recovers frames bit by bit, which catches a reversed data order or a missing or swapped marker.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

  // Power/initialisation state of the transmitter
  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_INIT = 2'd1,
    PS_RUN  = 2'd2
  } pstate_e;

  // Framing markers added around every word
  localparam int   ECS_FRAME_OVH = 2;
  localparam logic ECS_START_LVL = 1'b1;
  localparam logic ECS_STOP_LVL  = 1'b0;

endpackage

// File: rtl/ecs_capture.sv
module ecs_capture #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wclk_i,
  input  logic              cap_rise_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] hold_o
);

  logic              wclk_q;
  logic              wrise;
  logic              wfall;
  logic              cap_stb;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] hold_d;

  // Edge detection on the sampled word clock
  always_comb begin
    wrise   = wclk_i & ~wclk_q;
    wfall   = ~wclk_i & wclk_q;
    cap_stb = cap_rise_i ? wrise : wfall;
    hold_d  = cap_stb ? din_i : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q <= 1'b0;
      hold_q <= '0;
    end else begin
      wclk_q <= wclk_i;
      if (cap_stb) begin
        hold_q <= hold_d;
      end
    end
  end

  assign hold_o = hold_q;

  AST_HOLD_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> $stable(hold_q)); // R7

endmodule

// File: rtl/ecs_ctrl.sv
module ecs_ctrl
  import ecs_pkg::*;
#(
  parameter int INIT_WORDS = 510,
  parameter int SYNC_QUAL  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic pwr_n_i,
  input  logic sync_a_i,
  input  logic sync_b_i,
  output logic load_live_o,
  output logic load_sync_o
);

  localparam int            IW        = $clog2(INIT_WORDS + 1);
  localparam int            QW        = $clog2(SYNC_QUAL + 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_WORDS);
  localparam logic [QW-1:0] QUAL_MAX  = QW'(SYNC_QUAL);

  pstate_e       st_q, st_d;
  logic [IW-1:0] icnt_q, icnt_d;
  logic [QW-1:0] qcnt_q, qcnt_d;
  logic          sync_any;
  logic          load_live;
  logic          icnt_en;
  logic          qcnt_en;

  // Next-state logic
  always_comb begin
    sync_any  = sync_a_i | sync_b_i;
    st_d      = st_q;
    icnt_d    = icnt_q;
    qcnt_d    = qcnt_q;
    load_live = 1'b0;
    if (!pwr_n_i) begin
      st_d   = PS_OFF;
      icnt_d = '0;
      qcnt_d = '0;
    end else begin
      if ((st_q != PS_OFF) && tick_i) begin
        if (!sync_any) begin
          qcnt_d = '0;
        end else if (qcnt_q != QUAL_MAX) begin
          qcnt_d = qcnt_q + 1'b1;
        end
      end
      unique case (st_q)
        PS_OFF: begin
          st_d   = PS_INIT;
          icnt_d = '0;
        end
        PS_INIT: begin
          if (tick_i) begin
            if (icnt_q == INIT_LAST) begin
              st_d      = PS_RUN;
              load_live = 1'b1;
            end else begin
              icnt_d = icnt_q + 1'b1;
            end
          end
        end
        PS_RUN: begin
          load_live = tick_i;
        end
        default: begin
          st_d = PS_OFF;
        end
      endcase
    end
  end

  assign icnt_en     = (icnt_d != icnt_q);
  assign qcnt_en     = (qcnt_d != qcnt_q);
  assign load_live_o = load_live;
  assign load_sync_o = tick_i & (qcnt_d == QUAL_MAX);

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_INIT;
      icnt_q <= '0;
      qcnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (icnt_en) begin
        icnt_q <= icnt_d;
      end
      if (qcnt_en) begin
        qcnt_q <= qcnt_d;
      end
    end
  end

  AST_QUAL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt_q <= QUAL_MAX); // R4

  AST_SYNC_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !sync_a_i && !sync_b_i) |-> !load_sync_o); // R6

  AST_OFF_NEVER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_OFF) |=> (st_q != PS_RUN)); // R9

  AST_INIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    icnt_q <= INIT_LAST); // R9

endmodule

// File: rtl/ecs_shift.sv
module ecs_shift
  import ecs_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_n_i,
  input  logic              den_i,
  input  logic              load_live_i,
  input  logic              load_sync_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic              tick_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);

  localparam int            FRAME_W  = DATA_W + ECS_FRAME_OVH;
  localparam int            CW       = $clog2(FRAME_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(FRAME_W - 1);

  logic [CW-1:0]      cnt_q, cnt_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [FRAME_W-1:0] sync_pat;
  logic [FRAME_W-1:0] data_frame;
  logic               live_q, live_d;
  logic               oe_q, oe_d;
  logic               tick;

  // Training pattern: first half ones, second half zeros (bit 0 goes first)
  for (genvar gi = 0; gi < FRAME_W; gi++) begin : g_sync
    assign sync_pat[gi] = (gi < FRAME_W / 2);
  end

  always_comb begin
    tick       = (cnt_q == CNT_LAST);
    cnt_d      = tick ? '0 : cnt_q + 1'b1;
    data_frame = {ECS_STOP_LVL, hold_i, ECS_START_LVL};
    if (!pwr_n_i) begin
      shreg_d = '0;
      live_d  = 1'b0;
    end else if (tick) begin
      shreg_d = load_sync_i ? sync_pat : data_frame;
      live_d  = load_live_i;
    end else begin
      shreg_d = {1'b0, shreg_q[FRAME_W-1:1]};
      live_d  = live_q;
    end
    oe_d = den_i & pwr_n_i & live_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shreg_q <= '0;
      live_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      live_q  <= live_d;
      oe_q    <= oe_d;
    end
  end

  assign tick_o   = tick;
  assign sdo_o    = shreg_q[0] & oe_q;
  assign sdo_oe_o = oe_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R3

  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && cnt_q == '0) |-> shreg_q[0]); // R1

  AST_STOP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && cnt_q == CNT_LAST) |-> !shreg_q[0]); // R1

  AST_DEN_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    !den_i |=> (!sdo_oe_o && !sdo_o)); // R8

  AST_PWR_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n_i |=> !sdo_oe_o); // R9

endmodule

// File: rtl/emb_clk_ser.sv
module emb_clk_ser #(
  parameter int DATA_W     = 10,
  parameter int INIT_WORDS = 510,
  parameter int SYNC_QUAL  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wclk_i,
  input  logic              cap_rise_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              sync_a_i,
  input  logic              sync_b_i,
  input  logic              den_i,
  input  logic              pwr_n_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);

  logic [DATA_W-1:0] hold;
  logic              tick;
  logic              load_live;
  logic              load_sync;

  ecs_capture #(.DATA_W(DATA_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .wclk_i     (wclk_i),
    .cap_rise_i (cap_rise_i),
    .din_i      (din_i),
    .hold_o     (hold)
  );

  ecs_ctrl #(.INIT_WORDS(INIT_WORDS), .SYNC_QUAL(SYNC_QUAL)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .pwr_n_i     (pwr_n_i),
    .sync_a_i    (sync_a_i),
    .sync_b_i    (sync_b_i),
    .load_live_o (load_live),
    .load_sync_o (load_sync)
  );

  ecs_shift #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_n_i     (pwr_n_i),
    .den_i       (den_i),
    .load_live_i (load_live),
    .load_sync_i (load_sync),
    .hold_i      (hold),
    .tick_o      (tick),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
  );

endmodule

// File: tb/emb_clk_ser_tb.sv
module emb_clk_ser_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wclk;
  logic       cap_rise;
  logic [9:0] din;
  logic       sync_a;
  logic       sync_b;
  logic       den;
  logic       pwr_n;
  logic       sdo;
  logic       sdo_oe;

  int    compared = 0;
  int    mismatched = 0;
  int    edge_n = 0;
  int    ph = 0;
  bit    din_auto = 0;
  bit    done = 0;
  string cur_req = "R3";

  // reference model state
  int        m_cnt, m_st, m_icnt, m_qual;
  logic      m_wprev, m_live, m_oe;
  logic [9:0]  m_hold;
  logic [11:0] m_frame;

  always #2 clk = ~clk;

  emb_clk_ser u_dut (
    .clk(clk), .rst_n(rst_n), .wclk_i(wclk), .cap_rise_i(cap_rise), .din_i(din),
    .sync_a_i(sync_a), .sync_b_i(sync_b), .den_i(den), .pwr_n_i(pwr_n),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  // word clock and changing word, driven away from the active edge
  always @(negedge clk) begin
    ph = (ph == 11) ? 0 : ph + 1;
    wclk <= (ph < 6);
    if (din_auto && ph == 3) din <= {din[8:0], din[9] ^ din[6]} ^ 10'h0A5;
  end

  // behavioural reference, advanced at every active edge
  always @(posedge clk) begin
    logic tick, cap, sany, go;
    if (!rst_n) begin
      m_cnt = 0; m_wprev = 0; m_hold = '0; m_st = 1; m_icnt = 0;
      m_qual = 0; m_live = 0; m_oe = 0; m_frame = '0; edge_n = 0;
    end else begin
      edge_n++;
      tick = (m_cnt == 11);
      cap  = cap_rise ? (wclk && !m_wprev) : (!wclk && m_wprev);
      sany = sync_a | sync_b;
      if (!pwr_n) begin
        m_st = 0; m_icnt = 0; m_qual = 0; m_live = 0; m_frame = '0;
      end else begin
        go = 0;
        if (m_st != 0 && tick) m_qual = sany ? ((m_qual < 5) ? m_qual + 1 : 5) : 0;
        if (m_st == 0) begin
          m_st = 1; m_icnt = 0;
        end else if (m_st == 1 && tick) begin
          if (m_icnt == 510) begin m_st = 2; go = 1; end
          else m_icnt++;
        end else if (m_st == 2) go = tick;
        if (tick) begin
          m_frame = (m_qual == 5) ? 12'b000000_111111 : {1'b0, m_hold, 1'b1};
          m_live  = go;
        end else m_frame = m_frame >> 1;
      end
      m_oe = den && pwr_n && m_live;
      m_cnt = tick ? 0 : m_cnt + 1;
      if (cap) m_hold = din;
      m_wprev = wclk;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (sdo !== (m_oe & m_frame[0]) || sdo_oe !== m_oe) begin
        mismatched++;
        $display("FAIL %s: edge %0d sdo=%b oe=%b expected sdo=%b oe=%b",
                 cur_req, edge_n, sdo, sdo_oe, m_oe & m_frame[0], m_oe);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ones_in_window(output int n);
    n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      n += int'(sdo);
    end
  endtask

  initial begin
    int e0, exp_edge, n;
    logic [23:0] bits;
    rst_n = 0; pwr_n = 1; den = 1; cap_rise = 1; sync_a = 0; sync_b = 0;
    din = 10'h2B5; wclk = 0;
    repeat (3) @(negedge clk);
    check("R9", int'(sdo_oe), 0, "oe during reset");
    rst_n = 1;

    // first live frame after reset: boundary 511 -> edge 6132
    cur_req = "R9";
    while (sdo_oe !== 1'b1 && edge_n < 7000) @(negedge clk);
    check("R9", edge_n, 6132, "edge of first live frame after reset");
    bits[0] = sdo;
    for (int i = 1; i < 24; i++) begin
      @(negedge clk);
      bits[i] = sdo;
    end
    check("R1", int'(bits[0]), 1, "start marker");
    check("R1", int'(bits[11]), 0, "stop marker");
    check("R2", int'(bits[10:1]), 'h2B5, "data bits lsb first");
    check("R3", int'(bits[12]), 1, "next frame start without gap");
    check("R3", int'(bits[23]), 0, "next frame stop");

    // capture edge selection with a word that changes mid high phase
    cur_req = "R7";
    din_auto = 1;
    repeat (240) @(negedge clk);
    cap_rise = 0;
    repeat (240) @(negedge clk);
    din_auto = 0;
    din = 10'h3FF;
    repeat (36) @(negedge clk);

    // request lasting exactly four boundaries: no sync frame
    cur_req = "R4";
    sync_a = 1;
    repeat (24) @(negedge clk);
    ones_in_window(n);
    check("R4", n, 11, "ones per frame while request unqualified");
    repeat (12) @(negedge clk);
    sync_a = 0;
    repeat (24) @(negedge clk);

    // qualified request: sync pattern
    cur_req = "R5";
    sync_b = 1;
    repeat (84) @(negedge clk);
    ones_in_window(n);
    check("R5", n, 6, "ones per sync frame");
    check("R5", int'(sdo_oe), 1, "oe during sync");
    cur_req = "R6";
    sync_b = 0;
    repeat (24) @(negedge clk);
    ones_in_window(n);
    check("R6", n, 11, "data resumes after requests drop");

    // enable masking
    cur_req = "R8";
    den = 0;
    repeat (2) @(negedge clk);
    check("R8", int'(sdo_oe), 0, "oe low after den low");
    ones_in_window(n);
    check("R8", n, 0, "sdo quiet while disabled");
    den = 1;
    repeat (2) @(negedge clk);
    check("R8", int'(sdo_oe), 1, "transmission resumes");

    // power-down and re-initialisation
    cur_req = "R9";
    pwr_n = 0;
    repeat (2) @(negedge clk);
    check("R9", int'(sdo_oe), 0, "oe low in power-down");
    repeat (40) @(negedge clk);
    pwr_n = 1;
    e0 = edge_n + 1;
    exp_edge = (e0 / 12 + 1) * 12 + 510 * 12;
    @(negedge clk);
    while (sdo_oe !== 1'b1 && edge_n < exp_edge + 100) @(negedge clk);
    check("R9", edge_n, exp_edge, "edge of first live frame after power-down");
    check("R1", int'(sdo), 1, "start marker after re-init");
    repeat (24) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL R3: watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule